// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block runs on the bus clock and decides which power state a multi-threaded processor core is in. The states are the running state, a halt powerdown, a snoop substate entered from halt, a stop-grant state, and a snoop substate entered from stop-grant. It reads per-thread halt requests and bus events: the halt-cycle completion strobe, the active-low stop-clock request, the acknowledge response strobe, snoop start and snoop completion. It also reads five wake events and a processor initialize request. From these it produces the present state, a core clock enable, a one-cycle initialize pulse, and one-shot delivery strobes for wake events that are still waiting.

Halt is entered only when every thread has halted and the halt bus cycle has finished. A wake event brings the core out of halt. Stop-grant is reached a fixed number of bus clocks after the acknowledge response, provided the stop-clock request is still asserted. In stop-grant, wake events are not acted on. Each one is recorded and delivered once, after the core returns to the running state. A snoop in either low-power state holds the matching snoop substate until the snoop is serviced, then returns to the state it came from.

Top module: `lp_state_ctrl`

## Requirements
- R1: After reset, `state` is 0 (running), `core_clk_en` is 1, and `init_pulse` and `evt_deliver` are 0. State codes: 0 running, 1 halt, 2 halt-snoop, 3 stop-grant, 4 grant-snoop.
- R2: From running, `halt_cyc_done` moves the state to 1 only if every bit of `halt_req` is set. With any thread not halted, the state stays 0.
- R3: In halt, any bit of `wake_evt`, or a wake event that is still waiting, moves the state to 0 at the next edge.
- R4: With `stop_clk_n` held low, the state becomes 3 exactly ENTRY_DLY (default 20) bus clocks after the edge that samples `sg_ack_resp` in state 0 or 1.
- R5: If `stop_clk_n` goes high before the delay expires, the count is abandoned and the state stays where it was.
- R6: In state 3, `stop_clk_n` going high returns the controller to the state stop-grant was entered from (0 or 1).
- R7: Wake events arriving outside state 0 produce no delivery strobe and do not change states 3 or 4. Each event type is delivered at most once after the return to state 0, however many times it occurred.
- R8: `evt_deliver` is one-hot or zero. Waiting events are delivered one per cycle in bit order: bit0 SMI, bit1 INIT, bit2 BINIT, bit3 NMI, bit4 INTR. A new event that arrives on its own delivery cycle is recorded again.
- R9: `hard_init` in state 3 gives a one-cycle `init_pulse` on the next cycle while the state stays 3. The later release of `stop_clk_n`, including a release in the same cycle as `hard_init`, then goes to state 0.
- R10: `hard_init` in halt gives `init_pulse` and moves the state to 0.
- R11: `snoop_start` moves state 1 to 2 and state 3 to 4. Each snoop state is held until `snoop_done`, then returns to 1 or 3 respectively.
- R12: In state 0, `smi_rsm` with `smi_rsm_halt` high moves to state 1. With `smi_rsm_halt` low the state stays 0.
- R13: `core_clk_en` is high exactly when the state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high controller reset |
| halt_req | input | NUM_THR | Per-thread halt (or monitor-wait) request, level |
| halt_cyc_done | input | 1 | Strobe: halt bus cycle completed |
| stop_clk_n | input | 1 | Stop-clock request, active low |
| sg_ack_resp | input | 1 | Strobe: response phase of the stop-grant acknowledge cycle |
| snoop_start | input | 1 | Strobe: bus snoop detected |
| snoop_done | input | 1 | Strobe: snoop serviced |
| wake_evt | input | 5 | Wake events, bit0 SMI, bit1 INIT, bit2 BINIT, bit3 NMI, bit4 INTR |
| hard_init | input | 1 | Processor initialize request |
| smi_rsm | input | 1 | Strobe: return from the SMI handler |
| smi_rsm_halt | input | 1 | Return target of `smi_rsm`: 1 halt, 0 running |
| state | output | 3 | Present state code |
| core_clk_en | output | 1 | Core clock enable |
| init_pulse | output | 1 | One-cycle initialize pulse |
| evt_deliver | output | 5 | One-shot delivery strobe per wake event type |

## Verification
Two pairs of functions can meet in one cycle. The first pair is releasing the stop-clock request and an initialize request. The bench provokes it by entering stop-grant from halt and then raising `stop_clk_n` and `hard_init` together. Going to running rather than back to halt shows that the initialize request overrides the return target. The second pair is delivering a waiting SMI and a fresh SMI on the same edge: the event is held for two cycles in the running state, and two consecutive delivery strobes must appear. A behavioural model checks every cycle alongside these directed checks.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam int NUM_EVT = 5;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_HALT  = 3'd1,
        ST_HSNP  = 3'd2,
        ST_GRANT = 3'd3,
        ST_GSNP  = 3'd4
    } lp_state_e;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    // lowest set bit wins (bit0 has top priority)
    function automatic evt_vec_t pick_first(input evt_vec_t v);
        evt_vec_t r;
        r = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (v[i]) r = evt_vec_t'(1) << i;
        end
        return r;
    endfunction

    function automatic logic grant_origin(input lp_state_e s);
        return (s == ST_RUN) || (s == ST_HALT);
    endfunction

endpackage

// File: rtl/lp_entry_timer.sv
module lp_entry_timer #(
    parameter int DLY = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic cancel,
    input  logic fire_ok,
    output logic expire
);
    localparam int CW = $clog2(DLY + 1);

    logic          armed;
    logic [CW-1:0] cnt;

    assign expire = armed && (cnt == CW'(DLY)) && fire_ok && !cancel;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (cancel) begin
            armed <= 1'b0;
        end else if (arm) begin
            armed <= 1'b1;
            cnt   <= CW'(1);
        end else if (expire) begin
            armed <= 1'b0;
        end else if (armed && cnt != CW'(DLY)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5
    cancel_kills_chk: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !armed);

endmodule

// File: rtl/lp_event_latch.sv
module lp_event_latch
    import lp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t wake,
    input  logic     deliver_en,
    output evt_vec_t deliver_q,
    output logic     pend_any
);
    evt_vec_t pend;
    evt_vec_t sel;

    assign sel      = deliver_en ? pick_first(pend) : '0;
    assign pend_any = |pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            deliver_q <= '0;
        end else begin
            pend      <= (pend & ~sel) | wake;
            deliver_q <= sel;
        end
    end

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(deliver_q));

    // R7
    held_when_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        !deliver_en |=> deliver_q == '0);

endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
    import lp_pkg::*;
#(
    parameter int NUM_THR = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_THR-1:0] halt_req,
    input  logic               halt_cyc_done,
    input  logic               stop_clk_n,
    input  logic               snoop_start,
    input  logic               snoop_done,
    input  logic               wake_any,
    input  logic               hard_init,
    input  logic               smi_rsm,
    input  logic               smi_rsm_halt,
    input  logic               expire,
    output lp_state_e          state_q
);
    lp_state_e state_d;
    lp_state_e home_q, home_d;

    always_comb begin
        state_d = state_q;
        home_d  = home_q;
        unique case (state_q)
            ST_RUN: begin
                if (expire) begin
                    state_d = ST_GRANT;
                    home_d  = ST_RUN;
                end else if ((&halt_req) && halt_cyc_done) begin
                    state_d = ST_HALT;
                end else if (smi_rsm && smi_rsm_halt) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (expire) begin
                    state_d = ST_GRANT;
                    home_d  = hard_init ? ST_RUN : ST_HALT;
                end else if (hard_init) begin
                    state_d = ST_RUN;
                end else if (snoop_start) begin
                    state_d = ST_HSNP;
                end else if (wake_any) begin
                    state_d = ST_RUN;
                end
            end
            ST_HSNP: begin
                if (hard_init)       state_d = ST_RUN;
                else if (snoop_done) state_d = ST_HALT;
            end
            ST_GRANT: begin
                if (stop_clk_n)       state_d = hard_init ? ST_RUN : home_q;
                else if (snoop_start) state_d = ST_GSNP;
                if (hard_init) home_d = ST_RUN;
            end
            ST_GSNP: begin
                if (snoop_done) state_d = ST_GRANT;
                if (hard_init)  home_d  = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            home_q  <= ST_RUN;
        end else begin
            state_q <= state_d;
            home_q  <= home_d;
        end
    end

    // R9
    grant_init_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GRANT && hard_init && !stop_clk_n && !snoop_start)
        |=> state_q == ST_GRANT);

    // R11
    hsnp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HSNP && !snoop_done && !hard_init) |=> state_q == ST_HSNP);

    // R5
    no_grant_released_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_clk_n && grant_origin(state_q)) |=> state_q != ST_GRANT);

    // R2
    partial_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !(&halt_req) && !smi_rsm) |=> state_q != ST_HALT);

endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
    import lp_pkg::*;
#(
    parameter int NUM_THR   = 2,
    parameter int ENTRY_DLY = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_THR-1:0] halt_req,
    input  logic               halt_cyc_done,
    input  logic               stop_clk_n,
    input  logic               sg_ack_resp,
    input  logic               snoop_start,
    input  logic               snoop_done,
    input  logic [4:0]         wake_evt,
    input  logic               hard_init,
    input  logic               smi_rsm,
    input  logic               smi_rsm_halt,
    output logic [2:0]         state,
    output logic               core_clk_en,
    output logic               init_pulse,
    output logic [4:0]         evt_deliver
);
    lp_state_e cur;
    logic      expire;
    logic      pend_any;
    logic      in_origin;
    evt_vec_t  deliv;

    assign in_origin = grant_origin(cur);

    lp_entry_timer #(.DLY(ENTRY_DLY)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .arm     (sg_ack_resp && !stop_clk_n && in_origin),
        .cancel  (stop_clk_n),
        .fire_ok (in_origin),
        .expire  (expire)
    );

    lp_event_latch u_events (
        .clk        (clk),
        .rst        (rst),
        .wake       (evt_vec_t'(wake_evt)),
        .deliver_en (cur == ST_RUN),
        .deliver_q  (deliv),
        .pend_any   (pend_any)
    );

    lp_fsm #(.NUM_THR(NUM_THR)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .halt_req      (halt_req),
        .halt_cyc_done (halt_cyc_done),
        .stop_clk_n    (stop_clk_n),
        .snoop_start   (snoop_start),
        .snoop_done    (snoop_done),
        .wake_any      ((|wake_evt) || pend_any),
        .hard_init     (hard_init),
        .smi_rsm       (smi_rsm),
        .smi_rsm_halt  (smi_rsm_halt),
        .expire        (expire),
        .state_q       (cur)
    );

    always_ff @(posedge clk) begin
        if (rst) init_pulse <= 1'b0;
        else     init_pulse <= hard_init;
    end

    assign state       = cur;
    assign core_clk_en = (cur == ST_RUN);
    assign evt_deliver = deliv;

    // R10
    halt_init_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_HALT && hard_init && !expire) |=> (cur == ST_RUN && init_pulse));

endmodule

// File: tb/lp_state_ctrl_tb.sv
module lp_state_ctrl_tb;
    localparam int DLY = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] halt_req = '0;
    logic       halt_cyc_done = 0, stop_clk_n = 1, sg_ack_resp = 0;
    logic       snoop_start = 0, snoop_done = 0, hard_init = 0;
    logic       smi_rsm = 0, smi_rsm_halt = 0;
    logic [4:0] wake_evt = '0;
    logic [2:0] state;
    logic       core_clk_en, init_pulse;
    logic [4:0] evt_deliver;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit model_live = 0, done = 0;

    always #4 clk = ~clk;

    lp_state_ctrl #(.NUM_THR(2), .ENTRY_DLY(DLY)) u_dut (
        .clk(clk), .rst(rst), .halt_req(halt_req), .halt_cyc_done(halt_cyc_done),
        .stop_clk_n(stop_clk_n), .sg_ack_resp(sg_ack_resp), .snoop_start(snoop_start),
        .snoop_done(snoop_done), .wake_evt(wake_evt), .hard_init(hard_init),
        .smi_rsm(smi_rsm), .smi_rsm_halt(smi_rsm_halt), .state(state),
        .core_clk_en(core_clk_en), .init_pulse(init_pulse), .evt_deliver(evt_deliver));

    // behavioural reference
    int ms = 0, mh = 0, mcnt = 0;
    bit marm = 0, minit = 0;
    bit [4:0] mpend = '0, mdel = '0;

    always @(posedge clk) begin
        int os, nh, sel;
        bit ok, ex, wk;
        if (rst) begin
            ms = 0; mh = 0; marm = 0; mcnt = 0; mpend = '0; mdel = '0; minit = 0;
        end else begin
            os = ms; nh = mh;
            ok = (os == 0 || os == 1);
            ex = marm && mcnt == DLY && ok && !stop_clk_n;
            wk = (wake_evt != 0) || (mpend != 0);
            sel = 0;
            if (os == 0)
                for (int i = 0; i < 5; i++)
                    if (sel == 0 && mpend[i]) sel = 1 << i;
            if (os == 0) begin
                if (ex) begin ms = 3; nh = 0; end
                else if (halt_req == 2'b11 && halt_cyc_done) ms = 1;
                else if (smi_rsm && smi_rsm_halt) ms = 1;
            end else if (os == 1) begin
                if (ex) begin ms = 3; nh = hard_init ? 0 : 1; end
                else if (hard_init) ms = 0;
                else if (snoop_start) ms = 2;
                else if (wk) ms = 0;
            end else if (os == 2) begin
                if (hard_init) ms = 0; else if (snoop_done) ms = 1;
            end else if (os == 3) begin
                if (stop_clk_n) ms = hard_init ? 0 : mh;
                else if (snoop_start) ms = 4;
                if (hard_init) nh = 0;
            end else begin
                if (snoop_done) ms = 3;
                if (hard_init) nh = 0;
            end
            mh = nh;
            if (stop_clk_n) marm = 0;
            else if (sg_ack_resp && ok) begin marm = 1; mcnt = 1; end
            else if (ex) marm = 0;
            else if (marm && mcnt != DLY) mcnt++;
            mpend = (mpend & ~5'(sel)) | wake_evt;
            mdel = 5'(sel);
            minit = hard_init;
            model_live = 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (model_live && !rst && !done) begin
            chk("MODEL state", int'(state), ms);
            chk("MODEL R13 clk_en", int'(core_clk_en), (ms == 0) ? 1 : 0);
            chk("MODEL init_pulse", int'(init_pulse), int'(minit));
            chk("MODEL deliver", int'(evt_deliver), int'(mdel));
        end
    end

    task automatic summary;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 50000", cyc);
            summary();
        end
    end

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_halt;
        halt_req = 2'b11; halt_cyc_done = 1; tick(); halt_cyc_done = 0;
    endtask

    task automatic enter_grant;
        stop_clk_n = 0; sg_ack_resp = 1; tick(); sg_ack_resp = 0;
        repeat (DLY) tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R1 state", int'(state), 0);
        chk("R1 clk_en", int'(core_clk_en), 1);
        chk("R1 deliver", int'(evt_deliver), 0);
        chk("R1 init_pulse", int'(init_pulse), 0);

        halt_req = 2'b01; halt_cyc_done = 1; tick(); halt_cyc_done = 0;
        chk("R2 one thread", int'(state), 0);
        go_halt();
        chk("R2 both threads", int'(state), 1);
        chk("R13 clk_en in halt", int'(core_clk_en), 0);

        snoop_start = 1; tick(); snoop_start = 0;
        chk("R11 halt snoop", int'(state), 2);
        repeat (3) tick();
        chk("R11 halt snoop held", int'(state), 2);
        snoop_done = 1; tick(); snoop_done = 0;
        chk("R11 back to halt", int'(state), 1);

        stop_clk_n = 0; sg_ack_resp = 1; tick(); sg_ack_resp = 0;
        repeat (10) tick();
        stop_clk_n = 1; tick();
        repeat (30) tick();
        chk("R5 cancelled", int'(state), 1);

        stop_clk_n = 0; tick();
        sg_ack_resp = 1; tick(); sg_ack_resp = 0;
        repeat (DLY - 1) tick();
        chk("R4 one before", int'(state), 1);
        tick();
        chk("R4 at delay", int'(state), 3);

        halt_req = 2'b00;
        wake_evt = 5'b00001; tick(); wake_evt = 0; tick();
        wake_evt = 5'b00001; tick();
        wake_evt = 5'b01000; tick(); tick();
        wake_evt = 5'b10000; tick(); wake_evt = 0; tick();
        chk("R7 grant kept", int'(state), 3);
        chk("R7 no delivery", int'(evt_deliver), 0);

        snoop_start = 1; tick(); snoop_start = 0;
        chk("R11 grant snoop", int'(state), 4);
        snoop_done = 1; tick(); snoop_done = 0;
        chk("R11 back to grant", int'(state), 3);

        hard_init = 1; tick(); hard_init = 0;
        chk("R9 init pulse", int'(init_pulse), 1);
        chk("R9 stays grant", int'(state), 3);
        tick();
        chk("R9 pulse ends", int'(init_pulse), 0);
        stop_clk_n = 1; tick();
        chk("R9 release to run", int'(state), 0);
        tick(); chk("R8 SMI first", int'(evt_deliver), 1);
        tick(); chk("R8 NMI second", int'(evt_deliver), 8);
        tick(); chk("R8 INTR third", int'(evt_deliver), 16);
        tick(); chk("R7 once each", int'(evt_deliver), 0);

        go_halt();
        enter_grant();
        chk("R6 in grant", int'(state), 3);
        stop_clk_n = 1; tick();
        chk("R6 back to halt", int'(state), 1);

        halt_req = 2'b00;
        wake_evt = 5'b00010; tick(); wake_evt = 0;
        chk("R3 wake to run", int'(state), 0);
        tick(); chk("R8 INIT delivered", int'(evt_deliver), 2);

        go_halt();
        hard_init = 1; tick(); hard_init = 0;
        chk("R10 run", int'(state), 0);
        chk("R10 pulse", int'(init_pulse), 1);

        halt_req = 2'b00;
        smi_rsm = 1; smi_rsm_halt = 1; tick(); smi_rsm = 0;
        chk("R12 resume to halt", int'(state), 1);
        wake_evt = 5'b10000; tick(); wake_evt = 0;
        chk("R3 INTR wakes", int'(state), 0);
        tick(); tick();
        smi_rsm = 1; smi_rsm_halt = 0; tick(); smi_rsm = 0;
        chk("R12 resume to run", int'(state), 0);

        wake_evt = 5'b00001; tick(); tick(); wake_evt = 0;
        chk("R8 relatch first", int'(evt_deliver), 1);
        tick(); chk("R8 relatch second", int'(evt_deliver), 1);
        tick(); chk("R8 relatch done", int'(evt_deliver), 0);

        go_halt();
        enter_grant();
        stop_clk_n = 1; hard_init = 1; tick(); hard_init = 0;
        chk("R9 release with init", int'(state), 0);
        halt_req = 2'b00;
        tick();
        chk("R13 clk_en run", int'(core_clk_en), 1);

        summary();
    end
endmodule